// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block sits on the controller side of an asynchronous DRAM whose row and column addresses share one bus. It turns host read and write requests into RAS#, CAS#, WE# and OE# strobes and a multiplexed address bus. All timing intervals are counted in system clock cycles and are set through configuration inputs.

After a row has been opened, the sequencer leaves RAS# low. Each later request to the same row costs only a new column address and one CAS# pulse. A request to a different row closes the page by raising RAS#. RAS# then stays high for the precharge count, and the new row is opened after that. Writes are always issued as early writes, so the DRAM never drives its outputs during a write. An optional limit on how long RAS# may stay low closes the page even while hits keep arriving.

The host offers a request with a valid/ready handshake. A request carries a flat address made of the row bits above the column bits, a write flag and the write data. Read data comes back with a one-cycle valid pulse, in request order. Refresh is handled by a separate block and is not part of this one.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, all four DRAM strobes are high (inactive), the data bus is not driven, no read-valid pulse is present and reqReady is high.
- R2: A read returns the data most recently written to the same row and column. The row part of reqAddr (upper ROW_W bits) appears zero-extended on dramAddr when RAS# falls. The column part (lower COL_W bits) appears on dramAddr when CAS# falls.
- R3: A request to the row that is already open produces a CAS# pulse with no new RAS# falling edge. With no requests and the RAS# limit disabled, the page stays open (RAS# low).
- R4: A request to a different row raises RAS#. RAS# then stays high for at least cfgPre cycles before it falls again for the new row.
- R5: Every write is an early write. WE# is low in the cycle before CAS# falls, OE# is high while CAS# is low, and dramDqOe is high with the write data on dramDqOut.
- R6: Each read produces exactly one single-cycle rdValid pulse. The pulses arrive in request order.
- R7: CAS# first falls at least cfgRcd cycles after RAS# falls. CAS# stays low for exactly cfgCasLow cycles. Between column strobes in one page, CAS# stays high for at least cfgCasPre cycles.
- R8: With cfgRasMaxEn set, the page is closed once RAS# has been low for cfgRasMax cycles, even if hits keep arriving. With no further requests, RAS# then stays high.
- R9: CAS# only falls while RAS# is low. RAS# only rises while CAS# is high. reqReady is never high while a CAS# pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request offered |
| reqReady | output | 1 | Sequencer accepts the request in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Row bits above column bits |
| reqWdata | input | DATA_W | Write data |
| rdValid | output | 1 | One-cycle read data valid pulse |
| rdData | output | DATA_W | Read data |
| cfgRcd | input | CNT_W | RAS-to-CAS delay count (at least 1) |
| cfgCasLow | input | CNT_W | CAS# low width in cycles (at least 1) |
| cfgCasPre | input | CNT_W | CAS# precharge count (at least 1) |
| cfgPre | input | CNT_W | RAS# precharge count (at least 1) |
| cfgRasMaxEn | input | 1 | Enables the maximum RAS-low limit |
| cfgRasMax | input | RMAX_W | Maximum RAS-low cycles before a forced close |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dramDqOut | output | DATA_W | Write data toward the DRAM |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | DATA_W | Read data from the DRAM |

## Verification
The bench drives mixed traffic over a few rows and checks it against a behavioural DRAM that latches the address on each strobe edge. A column mux that swapped or truncated fields would therefore return the wrong data, and so would a CAS# edge issued ahead of the column address. It counts RAS# falling edges across runs of hits. A sequencer that reopened the row on a hit, or failed to reopen it on a miss, would show the wrong count. Precharge, RAS-to-CAS and CAS# widths are measured against three different timing sets, so a counter that is off by one or ignores its setting breaks a measured interval. A burst of hits under a small RAS# limit exposes a controller that lets hits override the forced close.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROWSET,
    S_ACT,
    S_RCD,
    S_COLSET,
    S_CAS,
    S_CP,
    S_OPEN,
    S_PRE
  } seqState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchReq;  // capture the accepted request
    logic loadRow;   // put the latched row on the bus
    logic loadCol;   // put a column on the bus, set up data
    logic useLive;   // column/data taken straight from the request port
    logic colWrite;  // the column access is a write
    logic endCol;    // column strobe ends, release data bus
    logic capRead;   // sample read data
  } dpStrobe_t;

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RMAX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  output logic              reqReady,
  input  logic              rowHit,
  input  logic [CNT_W-1:0]  cfgRcd,
  input  logic [CNT_W-1:0]  cfgCasLow,
  input  logic [CNT_W-1:0]  cfgCasPre,
  input  logic [CNT_W-1:0]  cfgPre,
  input  logic              cfgRasMaxEn,
  input  logic [RMAX_W-1:0] cfgRasMax,
  output dpStrobe_t         strobe,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              oeN
);

  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [RMAX_W-1:0] rasCnt;
  logic              wrLat;
  logic              pending;
  logic              cntDone;
  logic              expired;
  logic              accept;
  logic              openHit;

  assign cntDone  = (cnt <= CNT_W'(1));
  assign expired  = cfgRasMaxEn && (rasCnt >= cfgRasMax);
  assign reqReady = (state == S_IDLE) || ((state == S_OPEN) && !expired);
  assign accept   = reqValid && reqReady;
  assign openHit  = (state == S_OPEN) && accept && rowHit;

  always_comb begin
    strobe          = '0;
    strobe.latchReq = accept;
    strobe.loadRow  = (state == S_ROWSET);
    strobe.loadCol  = ((state == S_RCD) && cntDone) || openHit;
    strobe.useLive  = openHit;
    strobe.colWrite = openHit ? reqWrite : wrLat;
    strobe.endCol   = (state == S_CAS) && cntDone;
    strobe.capRead  = (state == S_CAS) && cntDone && !wrLat;
  end

  // length of the current RAS-low period, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasCnt <= '0;
    end else if (rasN) begin
      rasCnt <= '0;
    end else if (rasCnt != '1) begin
      rasCnt <= rasCnt + RMAX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wrLat   <= 1'b0;
      pending <= 1'b0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
      oeN     <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            wrLat <= reqWrite;
            state <= S_ROWSET;
          end
        end
        S_ROWSET: state <= S_ACT;
        S_ACT: begin
          rasN  <= 1'b0;
          cnt   <= cfgRcd;
          state <= S_RCD;
        end
        S_RCD: begin
          if (cntDone) begin
            weN   <= ~wrLat;
            oeN   <= wrLat;
            state <= S_COLSET;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_COLSET: begin
          casN  <= 1'b0;
          cnt   <= cfgCasLow;
          state <= S_CAS;
        end
        S_CAS: begin
          if (cntDone) begin
            casN  <= 1'b1;
            weN   <= 1'b1;
            oeN   <= 1'b1;
            cnt   <= cfgCasPre;
            state <= S_CP;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_CP: begin
          if (cntDone) state <= S_OPEN;
          else         cnt   <= cnt - CNT_W'(1);
        end
        S_OPEN: begin
          if (expired) begin
            rasN    <= 1'b1;
            cnt     <= cfgPre;
            pending <= 1'b0;
            state   <= S_PRE;
          end else if (accept) begin
            wrLat <= reqWrite;
            if (rowHit) begin
              weN   <= ~reqWrite;
              oeN   <= reqWrite;
              state <= S_COLSET;
            end else begin
              rasN    <= 1'b1;
              cnt     <= cfgPre;
              pending <= 1'b1;
              state   <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (cntDone) begin
            state   <= pending ? S_ROWSET : S_IDLE;
            pending <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dps_dpath.sv
module dps_dpath
  import dps_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int AIN_W  = ROW_W + COL_W,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [AIN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dramDqIn,
  output logic              rowHit,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ROW_W-1:0]  liveRow;
  logic [COL_W-1:0]  liveCol;
  logic [ROW_W-1:0]  rowLat;
  logic [COL_W-1:0]  colLat;
  logic [DATA_W-1:0] wdLat;
  logic [ROW_W-1:0]  openRow;

  assign liveRow = reqAddr[AIN_W-1:COL_W];
  assign liveCol = reqAddr[COL_W-1:0];
  assign rowHit  = (liveRow == openRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowLat    <= '0;
      colLat    <= '0;
      wdLat     <= '0;
      openRow   <= '0;
      dramAddr  <= '0;
      dramDqOut <= '0;
      dramDqOe  <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        rowLat <= liveRow;
        colLat <= liveCol;
        wdLat  <= reqWdata;
      end
      if (strobe.loadRow) begin
        dramAddr <= ADDR_W'(rowLat);
        openRow  <= rowLat;
      end
      if (strobe.loadCol) begin
        dramAddr  <= strobe.useLive ? ADDR_W'(liveCol) : ADDR_W'(colLat);
        dramDqOut <= strobe.useLive ? reqWdata : wdLat;
        dramDqOe  <= strobe.colWrite;
      end
      if (strobe.endCol) dramDqOe <= 1'b0;
      rdValid <= strobe.capRead;
      if (strobe.capRead) rdData <= dramDqIn;
    end
  end

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dps_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int RMAX_W = 8,
  localparam int AIN_W  = ROW_W + COL_W,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [AIN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  cfgRcd,
  input  logic [CNT_W-1:0]  cfgCasLow,
  input  logic [CNT_W-1:0]  cfgCasPre,
  input  logic [CNT_W-1:0]  cfgPre,
  input  logic              cfgRasMaxEn,
  input  logic [RMAX_W-1:0] cfgRasMax,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);

  dpStrobe_t strobe;
  logic      rowHit;

  dps_ctrl #(.CNT_W(CNT_W), .RMAX_W(RMAX_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqReady   (reqReady),
    .rowHit     (rowHit),
    .cfgRcd     (cfgRcd),
    .cfgCasLow  (cfgCasLow),
    .cfgCasPre  (cfgCasPre),
    .cfgPre     (cfgPre),
    .cfgRasMaxEn(cfgRasMaxEn),
    .cfgRasMax  (cfgRasMax),
    .strobe     (strobe),
    .rasN       (dramRasN),
    .casN       (dramCasN),
    .weN        (dramWeN),
    .oeN        (dramOeN)
  );

  dps_dpath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .dramDqIn (dramDqIn),
    .rowHit   (rowHit),
    .dramAddr (dramAddr),
    .dramDqOut(dramDqOut),
    .dramDqOe (dramDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int CNT_W  = 4,
  parameter int RMAX_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic              dramRasN,
  input logic              dramCasN,
  input logic              dramWeN,
  input logic              dramOeN,
  input logic              dramDqOe,
  input logic [CNT_W-1:0]  cfgRcd,
  input logic [CNT_W-1:0]  cfgCasLow,
  input logic [CNT_W-1:0]  cfgCasPre,
  input logic [CNT_W-1:0]  cfgPre,
  input logic              cfgRasMaxEn,
  input logic [RMAX_W-1:0] cfgRasMax
);

  logic [CNT_W:0] hiCnt;
  logic           closedOnce;
  logic [15:0]    loCnt;
  logic [15:0]    loBound;

  assign loBound = 16'(cfgRasMax) + 16'(cfgRcd) + 16'(cfgCasLow) + 16'(cfgCasPre) + 16'd4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt      <= '0;
      closedOnce <= 1'b0;
      loCnt      <= '0;
    end else begin
      if (!dramRasN)      hiCnt <= '0;
      else if (hiCnt != '1) hiCnt <= hiCnt + 1'b1;
      if ($rose(dramRasN)) closedOnce <= 1'b1;
      if (dramRasN || !cfgRasMaxEn) loCnt <= '0;
      else if (loCnt != '1)         loCnt <= loCnt + 16'd1;
    end
  end

  // R9
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> !dramRasN);

  // R9
  ras_close_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramRasN) |-> dramCasN);

  // R9
  ready_idle_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> dramCasN);

  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramWeN) |-> (!$past(dramWeN) && dramOeN && dramDqOe));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && closedOnce) |-> (hiCnt >= (CNT_W+1)'(cfgPre)));

  // R8
  ras_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRasMaxEn && !dramRasN) |-> (loCnt <= loBound));

endmodule

bind dram_page_seq dps_chk #(.CNT_W(CNT_W), .RMAX_W(RMAX_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .rdValid    (rdValid),
  .dramRasN   (dramRasN),
  .dramCasN   (dramCasN),
  .dramWeN    (dramWeN),
  .dramOeN    (dramOeN),
  .dramDqOe   (dramDqOe),
  .cfgRcd     (cfgRcd),
  .cfgCasLow  (cfgCasLow),
  .cfgCasPre  (cfgCasPre),
  .cfgPre     (cfgPre),
  .cfgRasMaxEn(cfgRasMaxEn),
  .cfgRasMax  (cfgRasMax)
);

// File: tb/test_dram_page_seq.sv
`timescale 1ns/1ps
module test_dram_page_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [3:0]  cfgRcd = 4'd2, cfgCasLow = 4'd2, cfgCasPre = 4'd1, cfgPre = 4'd3;
  logic        cfgRasMaxEn = 1'b0;
  logic [7:0]  cfgRasMax = 8'd255;
  logic        dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;
  logic [9:0]  dramAddr;
  logic [15:0] dramDqOut, dramDqIn;

  always #10 clk = ~clk;

  dram_page_seq i_dram_page_seq (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural DRAM and pin monitor
  logic [15:0] dmem [64];
  logic [15:0] expMem [64];
  logic [15:0] expQ [$];
  logic [1:0]  latRow = '0;
  logic [3:0]  latCol = '0;
  logic prevRas = 1, prevCas = 1, prevWe = 1, seenClose = 0, firstCas = 0;
  int rasFalls = 0, rasHiRun = 0, sinceRas = 0, casLoRun = 0, casHiRun = 0;
  int ewErr = 0, rcdErr = 0, casLoErr = 0, casPreErr = 0, preErr = 0, strobeErr = 0;
  int writesSeen = 0, readsIssued = 0, rdPulses = 0;

  always_comb dramDqIn = (!dramCasN && dramWeN && !dramOeN) ? dmem[{latRow, latCol}] : 16'hDEAD;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (prevRas && !dramRasN) begin
      rasFalls++;
      latRow = dramAddr[1:0];
      if (seenClose && rasHiRun < int'(cfgPre)) preErr++;
      sinceRas = 0;
      firstCas = 1;
    end else if (!dramRasN) sinceRas++;
    if (!prevRas && dramRasN) begin
      seenClose = 1;
      if (!dramCasN) strobeErr++;
    end
    if (dramRasN) rasHiRun++; else rasHiRun = 0;
    if (prevCas && !dramCasN) begin
      if (dramRasN) strobeErr++;
      latCol = dramAddr[3:0];
      if (firstCas && sinceRas < int'(cfgRcd)) rcdErr++;
      if (!firstCas && casHiRun < int'(cfgCasPre)) casPreErr++;
      firstCas = 0;
      if (!dramWeN) begin
        if (prevWe || !dramOeN || !dramDqOe) ewErr++;
        dmem[{latRow, latCol}] = dramDqOut;
        writesSeen++;
      end
      casLoRun = 0;
    end
    if (!prevCas && dramCasN) begin
      if (casLoRun != int'(cfgCasLow)) casLoErr++;
      casHiRun = 0;
    end
    if (!dramCasN) casLoRun++; else casHiRun++;
    if (rdValid) begin
      rdPulses++;
      if (expQ.size() == 0) check(0, "R6 unexpected read pulse", 32'(rdData), 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R2 read data", 32'(rdData), 32'(e));
      end
    end
    prevRas = dramRasN; prevCas = dramCasN; prevWe = dramWeN;
  end

  task automatic issue(input bit wr, input int row, input int col, input logic [15:0] d);
    reqValid = 1; reqWrite = wr;
    reqAddr = {10'(row), 9'(col)};
    reqWdata = d;
    forever begin
      if (reqReady) begin @(negedge clk); break; end
      @(negedge clk);
    end
    if (wr) expMem[{2'(row), 4'(col)}] = d;
    else begin expQ.push_back(expMem[{2'(row), 4'(col)}]); readsIssued++; end
    reqValid = 0;
  endtask

  task automatic randomOps(input int n);
    for (int i = 0; i < n; i++)
      issue(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 15), 16'($urandom));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'd20240));
    for (int i = 0; i < 64; i++) begin dmem[i] = '0; expMem[i] = '0; end
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dramRasN && dramCasN && dramWeN && dramOeN, "R1 strobes idle",
          {dramRasN, dramCasN, dramWeN, dramOeN}, 4'hF);
    check(!dramDqOe && !rdValid && reqReady, "R1 bus/ready", {dramDqOe, rdValid, reqReady}, 3'b001);
    rstN = 1;
    idle(2);

    // R3 page hits: one RAS fall for a run of accesses in one row
    f0 = rasFalls;
    issue(1, 0, 1, 16'hA5A5);
    issue(1, 0, 2, 16'h1234);
    issue(0, 0, 1, 0);
    issue(0, 0, 2, 0);
    idle(20);
    check(rasFalls - f0 == 1, "R3 hits reuse open row", rasFalls - f0, 1);
    check(!dramRasN, "R3 page stays open when idle", dramRasN, 0);

    // R4 miss opens a new row
    f0 = rasFalls;
    issue(0, 1, 5, 0);
    issue(1, 1, 6, 16'hBEEF);
    issue(0, 0, 2, 0);
    idle(20);
    check(rasFalls - f0 == 2, "R4 misses reopen rows", rasFalls - f0, 2);

    randomOps(150);
    idle(20);
    cfgRcd = 1; cfgCasLow = 1; cfgCasPre = 1; cfgPre = 1;
    randomOps(150);
    idle(20);
    cfgRcd = 3; cfgCasLow = 3; cfgCasPre = 2; cfgPre = 4;
    randomOps(150);
    idle(20);

    // R8 forced close under a burst of hits
    cfgRasMax = 8'd6; cfgRasMaxEn = 1;
    idle(30);
    check(dramRasN, "R8 limit closes idle page", dramRasN, 1);
    f0 = rasFalls;
    for (int i = 0; i < 10; i++) issue(1'(i & 1), 2, i, 16'(16'h5000 + i));
    idle(40);
    check(rasFalls - f0 >= 2, "R8 hits reopen after forced close", rasFalls - f0, 2);
    check(dramRasN, "R8 page closed after limit", dramRasN, 1);
    idle(20);

    check(expQ.size() == 0, "R6 all reads answered", expQ.size(), 0);
    check(rdPulses == readsIssued, "R6 one pulse per read", rdPulses, readsIssued);
    check(ewErr == 0 && writesSeen > 0, "R5 early write strobes", ewErr, 0);
    check(rcdErr == 0, "R7 ras-to-cas delay", rcdErr, 0);
    check(casLoErr == 0, "R7 cas low width", casLoErr, 0);
    check(casPreErr == 0, "R7 cas precharge", casPreErr, 0);
    check(preErr == 0, "R4 ras precharge", preErr, 0);
    check(strobeErr == 0, "R9 strobe ordering", strobeErr, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule